// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second ALU operand of a 32-bit data-processing datapath, together with the carry that the shifter passes on to the flag logic. It takes a register value and moves it by a shift type and an 8-bit amount. It also handles a separate immediate-operand mode, in which an 8-bit constant is rotated into place. The block has no clock and no internal state. Its outputs follow its inputs within the same cycle.

A shift amount of zero, of exactly the data width, or of anything larger has its own meaning. The meaning also depends on whether the amount came from a register or from the instruction's immediate field. A register-supplied zero leaves both the operand and the carry untouched. An immediate zero turns the logical and arithmetic right shifts into shifts by 32. For the rotate, an immediate zero becomes a one-bit rotate through the carry flag. Decoding, the ALU and flag writeback are outside the block.

Top module: `barrel_opnd_shifter`

## Requirements
- R1: The shift type is coded as 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The outputs are combinational: with all inputs at zero, the operand is 0 and the carry is 0 in the same cycle.
- R2: When `amt_from_reg_i` is 1, `imm_mode_i` is 0 and `amt_i` is 0, `operand_o` equals `opnd_i` and `carry_o` equals `carry_i`. This holds for every shift type.
- R3: Logical left. An amount of 0 gives the operand unchanged with `carry_i`. An amount n from 1 to 31 gives the left-shifted value with carry equal to bit 32-n. An amount of 32 gives 0 with carry equal to bit 0. An amount above 32 gives 0 with carry 0.
- R4: Logical right. An amount n from 1 to 31 gives the right-shifted value with carry equal to bit n-1. An immediate 0, or an amount of 32, gives 0 with carry equal to bit 31. An amount above 32 gives 0 with carry 0.
- R5: Arithmetic right. An amount n from 1 to 31 gives the sign-filled shift with carry equal to bit n-1. An immediate 0, or any amount of 32 or more, fills every bit with bit 31, and the carry is also bit 31.
- R6: Rotate right with an immediate amount of 0 rotates through the carry. The result is `{carry_i, opnd_i[31:1]}` and the carry is bit 0 of the operand.
- R7: Rotate right with a nonzero amount uses the amount modulo 32. If that value is 0, the operand is unchanged and the carry is bit 31. Otherwise the operand is rotated by that value and the carry is bit (value-1).
- R8: When `imm_mode_i` is 1, the operand is `imm_val_i` zero-extended to 32 bits and rotated right by twice `imm_rot_i`. The carry equals `carry_i`. The register operand and the shift inputs have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Register value to be shifted |
| kind_i | input | 2 | Shift type (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| amt_i | input | 8 | Shift amount |
| amt_from_reg_i | input | 1 | 1: the amount came from a register; 0: it came from the immediate field |
| carry_i | input | 1 | Incoming carry flag |
| imm_mode_i | input | 1 | Selects the rotated-constant operand |
| imm_val_i | input | 8 | 8-bit constant for immediate mode |
| imm_rot_i | input | 4 | Rotate field; the rotation is twice this value |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Both results are due in the same cycle as the stimulus, because no register lies between any input and either output. The driver task applies one stimulus shortly after each rising edge and queues the value expected for it. The monitor takes the oldest queued item at the following falling edge and compares it with both outputs. By that time the combinational paths have settled, and the next stimulus has not yet been applied.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

endpackage

// File: rtl/bsh_lin_shift.sv
module bsh_lin_shift
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  sh_kind_e          kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              amt_imm_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cy_o
);

  localparam int XW = DATA_W + 1;

  // Left shift on a widened word: the top bit catches the last bit shifted out.
  function automatic logic [XW-1:0] f_lsl(logic [DATA_W-1:0] x, logic [AMT_W-1:0] n);
    return {1'b0, x} << n;
  endfunction

  // Right shift on a widened word: the bottom bit catches the last bit out.
  function automatic logic [XW-1:0] f_lsr(logic [DATA_W-1:0] x, logic [AMT_W-1:0] n);
    return {x, 1'b0} >> n;
  endfunction

  function automatic logic [XW-1:0] f_asr(logic [DATA_W-1:0] x, logic [AMT_W-1:0] n);
    return XW'($signed({x, 1'b0}) >>> n);
  endfunction

  logic             w_amt_zero;
  logic [AMT_W-1:0] w_amt_right;
  logic [XW-1:0]    w_lsl, w_lsr, w_asr;

  assign w_amt_zero  = (amt_i == '0);
  // An immediate zero means a full-width shift for the right shifts.
  assign w_amt_right = (w_amt_zero && amt_imm_i) ? AMT_W'(DATA_W) : amt_i;

  assign w_lsl = f_lsl(x_i, amt_i);
  assign w_lsr = f_lsr(x_i, w_amt_right);
  assign w_asr = f_asr(x_i, w_amt_right);

  always_comb begin
    val_o = x_i;
    cy_o  = cy_i;
    unique case (kind_i)
      SH_LSL: begin
        if (!w_amt_zero) begin
          val_o = w_lsl[DATA_W-1:0];
          cy_o  = w_lsl[DATA_W];
        end
      end
      SH_LSR: begin
        val_o = w_lsr[XW-1:1];
        cy_o  = w_lsr[0];
      end
      SH_ASR: begin
        val_o = w_asr[XW-1:1];
        cy_o  = w_asr[0];
      end
      default: begin
        val_o = x_i;
        cy_o  = cy_i;
      end
    endcase
  end

  always_comb begin
    if (kind_i == SH_LSL && int'(amt_i) > DATA_W)
      AST_LSL_FLUSH: assert (val_o == '0 && !cy_o) else $error("lsl flush"); // R3
    if (kind_i == SH_ASR && int'(amt_i) >= DATA_W)
      AST_ASR_FILL: assert ((val_o == '0 || val_o == '1) && cy_o == x_i[DATA_W-1]) else $error("asr fill"); // R5
  end

endmodule

// File: rtl/bsh_rotator.sv
module bsh_rotator #(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              amt_imm_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cy_o
);

  localparam int RW = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] f_ror(logic [DATA_W-1:0] x, logic [RW-1:0] m);
    return (x >> m) | (x << (DATA_W - int'(m)));
  endfunction

  logic              w_rrx;
  logic [RW-1:0]     w_mod;
  logic [DATA_W-1:0] w_rot;

  assign w_rrx = (amt_i == '0) && amt_imm_i;
  assign w_mod = amt_i[RW-1:0];
  assign w_rot = f_ror(x_i, w_mod);

  always_comb begin
    if (w_rrx) begin
      val_o = {cy_i, x_i[DATA_W-1:1]};
      cy_o  = x_i[0];
    end else if (amt_i == '0) begin
      val_o = x_i;
      cy_o  = cy_i;
    end else if (w_mod == '0) begin
      val_o = x_i;
      cy_o  = x_i[DATA_W-1];
    end else begin
      val_o = w_rot;
      cy_o  = w_rot[DATA_W-1];
    end
  end

  always_comb begin
    if (amt_i != '0)
      AST_ROR_KEEPS_ONES: assert ($countones(val_o) == $countones(x_i)) else $error("ror ones"); // R7
    if (w_rrx)
      AST_RRX_KEEPS_ONES: assert ($countones(val_o) + int'(cy_o) == $countones(x_i) + int'(cy_i)) else $error("rrx ones"); // R6
  end

endmodule

// File: rtl/bsh_imm_gen.sv
module bsh_imm_gen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] val_o
);

  localparam int RW = $clog2(DATA_W);

  function automatic logic [DATA_W-1:0] f_ror(logic [DATA_W-1:0] x, logic [RW-1:0] m);
    return (x >> m) | (x << (DATA_W - int'(m)));
  endfunction

  logic [DATA_W-1:0] w_ext;
  logic [RW-1:0]     w_dist;

  assign w_ext  = DATA_W'(imm_i);
  assign w_dist = RW'({rot_i, 1'b0});
  assign val_o  = f_ror(w_ext, w_dist);

  always_comb begin
    AST_IMM_KEEPS_ONES: assert ($countones(val_o) == $countones(imm_i)) else $error("imm ones"); // R8
  end

endmodule

// File: rtl/barrel_opnd_shifter.sv
module barrel_opnd_shifter
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [DATA_W-1:0] opnd_i,
  input  logic [1:0]        kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic              amt_from_reg_i,
  input  logic              carry_i,
  input  logic              imm_mode_i,
  input  logic [IMM_W-1:0]  imm_val_i,
  input  logic [ROT_W-1:0]  imm_rot_i,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o
);

  sh_kind_e          w_kind;
  logic              w_amt_imm;
  logic              w_reg_zero;
  logic              w_use_rot;
  logic [DATA_W-1:0] w_lin_val, w_rot_val, w_imm_val;
  logic              w_lin_cy, w_rot_cy;

  assign w_kind     = sh_kind_e'(kind_i);
  assign w_amt_imm  = !amt_from_reg_i;
  assign w_reg_zero = amt_from_reg_i && (amt_i == '0);
  assign w_use_rot  = (w_kind == SH_ROR);

  bsh_lin_shift #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_lin (
    .x_i       (opnd_i),
    .kind_i    (w_kind),
    .amt_i     (amt_i),
    .amt_imm_i (w_amt_imm),
    .cy_i      (carry_i),
    .val_o     (w_lin_val),
    .cy_o      (w_lin_cy)
  );

  bsh_rotator #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_rot (
    .x_i       (opnd_i),
    .amt_i     (amt_i),
    .amt_imm_i (w_amt_imm),
    .cy_i      (carry_i),
    .val_o     (w_rot_val),
    .cy_o      (w_rot_cy)
  );

  bsh_imm_gen #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm (
    .imm_i (imm_val_i),
    .rot_i (imm_rot_i),
    .val_o (w_imm_val)
  );

  always_comb begin
    if (imm_mode_i) begin
      operand_o = w_imm_val;
      carry_o   = carry_i;
    end else if (w_reg_zero) begin
      operand_o = opnd_i;
      carry_o   = carry_i;
    end else if (w_use_rot) begin
      operand_o = w_rot_val;
      carry_o   = w_rot_cy;
    end else begin
      operand_o = w_lin_val;
      carry_o   = w_lin_cy;
    end
  end

  always_comb begin
    if (!imm_mode_i && w_kind == SH_LSR && int'(amt_i) > DATA_W)
      AST_LSR_FLUSH: assert (operand_o == '0 && !carry_o) else $error("lsr flush"); // R4
  end

endmodule

// File: tb/barrel_opnd_shifter_bench.sv
module barrel_opnd_shifter_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opnd = '0;
  logic [1:0]  kind = '0;
  logic [7:0]  amt = '0;
  logic        from_reg = 1'b0;
  logic        cin = 1'b0;
  logic        imode = 1'b0;
  logic [7:0]  ival = '0;
  logic [3:0]  irot = '0;
  logic [31:0] operand;
  logic        cout;

  always #2 clk = ~clk;

  barrel_opnd_shifter u_barrel_opnd_shifter (
    .opnd_i(opnd), .kind_i(kind), .amt_i(amt), .amt_from_reg_i(from_reg),
    .carry_i(cin), .imm_mode_i(imode), .imm_val_i(ival), .imm_rot_i(irot),
    .operand_o(operand), .carry_o(cout)
  );

  typedef struct {
    logic [31:0] v;
    logic        c;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // Reference: move one bit per step.
  task automatic model(input logic [1:0] k, input logic [7:0] n, input logic reg_src,
                       input logic ci, input logic [31:0] x,
                       output logic [31:0] r, output logic c, output string tag);
    int steps;
    r = x; c = ci;
    if (reg_src && n == 0) begin tag = "R2"; return; end
    case (k)
      2'd0: begin
        tag = "R3";
        for (int i = 0; i < int'(n); i++) begin c = r[31]; r = r << 1; end
      end
      2'd1: begin
        tag = "R4";
        steps = (n == 0) ? 32 : int'(n);
        for (int i = 0; i < steps; i++) begin c = r[0]; r = r >> 1; end
      end
      2'd2: begin
        tag = "R5";
        steps = (n == 0) ? 32 : int'(n);
        for (int i = 0; i < steps; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      end
      default: begin
        if (n == 0) begin
          tag = "R6";
          c = x[0]; r = {ci, x[31:1]};
        end else begin
          tag = "R7";
          steps = int'(n) % 32;
          if (steps == 0) c = x[31];
          for (int i = 0; i < steps; i++) begin r = {r[0], r[31:1]}; c = r[31]; end
        end
      end
    endcase
  endtask

  task automatic drive(input logic [1:0] k, input logic [7:0] n, input logic reg_src,
                       input logic ci, input logic [31:0] x, input logic im,
                       input logic [7:0] iv, input logic [3:0] ir);
    exp_t e;
    @(posedge clk); #1;
    opnd = x; kind = k; amt = n; from_reg = reg_src; cin = ci;
    imode = im; ival = iv; irot = ir;
    if (im) begin
      e.v = {24'd0, iv}; e.c = ci; e.tag = "R8";
      for (int i = 0; i < 2 * int'(ir); i++) e.v = {e.v[0], e.v[31:1]};
    end else begin
      model(k, n, reg_src, ci, x, e.v, e.c, e.tag);
    end
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (operand !== e.v || cout !== e.c) begin
        n_bad++;
        $display("FAIL %s: got %h/%b expected %h/%b", e.tag, operand, cout, e.v, e.c);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  amts [6] = '{8'd0, 8'd1, 8'd31, 8'd32, 8'd33, 8'd255};
    logic [31:0] ops  [4];
    repeat (3) @(posedge clk);
    #1;
    // R1: all-zero inputs give zero operand and zero carry at once
    n_cmp++;
    if (operand !== 32'd0 || cout !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got %h/%b expected 00000000/0", operand, cout);
    end
    rst = 1'b0;
    ops[0] = 32'h8000_0001;
    ops[1] = 32'h7FFF_FFFE;
    ops[2] = $urandom;
    ops[3] = $urandom | 32'h8000_0000;
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 6; a++)
        for (int s = 0; s < 2; s++)
          for (int c = 0; c < 2; c++)
            for (int o = 0; o < 4; o++)
              drive(2'(k), amts[a], s[0], c[0], ops[o], 1'b0, 8'd0, 4'd0);
    // R7: amount that is a multiple of 32 but nonzero
    drive(2'd3, 8'd64, 1'b0, 1'b0, 32'hC000_0001, 1'b0, 8'd0, 4'd0);
    drive(2'd3, 8'd5, 1'b1, 1'b1, 32'h0000_0013, 1'b0, 8'd0, 4'd0);
    // R8: rotated constants; shift inputs set to values that would change the result
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 2; c++)
        drive(2'(r % 4), 8'd3, c[0], c[0], $urandom, 1'b1, 8'hA5 ^ 8'(r), 4'(r));
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule